// File: doc/BRIEF.md
# Programmable Processor Event Counter

This block keeps one software-visible count of a single processor event. Software picks the event by writing an 8-bit event code and an 8-bit qualifier code, plus an enable bit, into a configuration register. On every clock the block looks at per-cycle status strobes from a core model and adds one to the count when the chosen event occurred in that cycle and the count is enabled. The strobes cover the causes that stop the core clock, a fixed-rate reference tick, micro-op retirement with its attributes, and last-level-cache reference and miss pulses.

The block applies the qualification rules of each event. Cycle events count only while no stop cause is active. Retirement events count whole instructions at their final micro-op. A repeated string instruction counts once, and a fault or a VM exit suppresses the count. A code pair outside the supported set freezes the count and raises a flag. The count is 48 bits wide and wraps to zero, setting a sticky overflow flag that software clears.

Top module: `perf_event_counter`

## Requirements
- R1: With event code 0x3C and qualifier 0x00 the count rises by one in every enabled cycle in which none of st_lowpwr, st_halt, st_stopclk, st_thermal, st_fswitch is high.
- R2: Any single one of the five stop causes, held high, keeps both cycle events (0x3C with qualifier 0x00 or 0x01) from advancing.
- R3: With event code 0x3C and qualifier 0x01 the count rises by one in each cycle where ref_tick is high and no stop cause is active.
- R4: With event code 0xC0 and qualifier 0x00 the count rises by one for each cycle with rt_valid and rt_last both high; a retiring micro-op without rt_last adds nothing.
- R5: A final micro-op retiring with rt_rep_more high adds nothing to the 0xC0 count, so a repeated instruction adds exactly one, on its last iteration.
- R6: rt_fault or rt_vmexit high in the retirement cycle keeps events 0xC0, 0xC4 and 0xC5 from counting that retirement.
- R7: Event 0x2E with qualifier 0x4F counts cycles with llc_ref high; event 0x2E with qualifier 0x41 counts cycles with llc_miss high.
- R8: Event 0xC4 with qualifier 0x00 counts final micro-ops with rt_branch high; event 0xC5 with qualifier 0x00 counts those that also have rt_mispred high.
- R9: Any code pair other than the seven listed leaves the count unchanged and drives unsup_o high; a listed pair drives unsup_o low.
- R10: When the enable bit (configuration bit 16) is low the count does not change except by a software write.
- R11: An increment from all ones wraps the count to zero and sets ovf_o; ovf_o stays set until a write to address 2 with data bit 0 high.
- R12: A write to the count (address 1) in a cycle that also has an increment loads the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 configuration {en[16], qualifier[15:8], event[7:0]}, 1 count, 2 status clear |
| reg_wdata | input | CNT_W | Write data |
| st_lowpwr | input | 1 | Core in a low-power state other than normal operation |
| st_halt | input | 1 | Core halted |
| st_stopclk | input | 1 | External stop-clock request |
| st_thermal | input | 1 | Thermal throttling active |
| st_fswitch | input | 1 | Frequency-switch phase of a performance-state change |
| ref_tick | input | 1 | Fixed-frequency reference tick |
| rt_valid | input | 1 | A micro-op retires this cycle |
| rt_last | input | 1 | Retiring micro-op is its instruction's last |
| rt_rep_more | input | 1 | Repeated instruction has further iterations |
| rt_branch | input | 1 | Retiring instruction is a branch |
| rt_mispred | input | 1 | Retiring branch was mispredicted |
| rt_fault | input | 1 | Fault on this retirement |
| rt_vmexit | input | 1 | VM-exit condition on this retirement |
| llc_ref | input | 1 | Last-level-cache reference |
| llc_miss | input | 1 | Last-level-cache miss |
| count_o | output | CNT_W | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| unsup_o | output | 1 | Selected code pair is not supported |

## Verification
Every result is due one clock after the edge that captures its stimulus: the configuration and the count are registers, and unsup_o follows the configuration register combinationally. The bench changes inputs just after a rising edge and reads outputs just after the next rising edge, so each check sees exactly the edges it intends. A sweep of every event code against five qualifiers drives all strobes for one cycle and expects a gain of one only for the seven listed pairs.

// File: rtl/perf_evt_pkg.sv
package perf_evt_pkg;

    localparam int CFG_W = 17;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam logic [7:0] SEL_CYC    = 8'h3C;
    localparam logic [7:0] SEL_INST   = 8'hC0;
    localparam logic [7:0] SEL_LLC    = 8'h2E;
    localparam logic [7:0] SEL_BR     = 8'hC4;
    localparam logic [7:0] SEL_BRMISS = 8'hC5;

    localparam logic [7:0] QUAL_NONE  = 8'h00;
    localparam logic [7:0] QUAL_REF   = 8'h01;
    localparam logic [7:0] QUAL_LREF  = 8'h4F;
    localparam logic [7:0] QUAL_LMISS = 8'h41;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_CORE    = 3'd1,
        EV_REFCYC  = 3'd2,
        EV_INST    = 3'd3,
        EV_LREF    = 3'd4,
        EV_LMISS   = 3'd5,
        EV_BRANCH  = 3'd6,
        EV_BRMISS  = 3'd7
    } evt_kind_e;

    localparam int N_KIND = 8;

    typedef struct packed {
        logic       en;
        logic [7:0] qual;
        logic [7:0] sel;
    } cfg_t;

    typedef struct packed {
        logic lowpwr;
        logic halt;
        logic stopclk;
        logic thermal;
        logic fswitch;
    } stall_t;

    typedef struct packed {
        logic valid;
        logic last;
        logic rep_more;
        logic branch;
        logic mispred;
        logic fault;
        logic vmexit;
    } retire_t;

    function automatic evt_kind_e decode_kind(input logic [7:0] sel, input logic [7:0] qual);
        evt_kind_e k;
        k = EV_NONE;
        unique case (sel)
            SEL_CYC: begin
                if (qual == QUAL_NONE)     k = EV_CORE;
                else if (qual == QUAL_REF) k = EV_REFCYC;
            end
            SEL_INST:   if (qual == QUAL_NONE) k = EV_INST;
            SEL_LLC: begin
                if (qual == QUAL_LREF)       k = EV_LREF;
                else if (qual == QUAL_LMISS) k = EV_LMISS;
            end
            SEL_BR:     if (qual == QUAL_NONE) k = EV_BRANCH;
            SEL_BRMISS: if (qual == QUAL_NONE) k = EV_BRMISS;
            default:    k = EV_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/perf_evt_decode.sv
module perf_evt_decode
    import perf_evt_pkg::*;
(
    input  cfg_t      cfg,
    output evt_kind_e kind,
    output logic      unsup
);
    always_comb begin
        kind  = decode_kind(cfg.sel, cfg.qual);
        unsup = (kind == EV_NONE);
    end
endmodule

// File: rtl/perf_evt_qualify.sv
module perf_evt_qualify
    import perf_evt_pkg::*;
(
    input  evt_kind_e kind,
    input  stall_t    stall,
    input  logic      ref_tick,
    input  retire_t   rt,
    input  logic      llc_ref,
    input  logic      llc_miss,
    output logic      hit
);
    logic              running;
    logic              ret_ok;
    logic [N_KIND-1:0] hits;

    always_comb begin
        running = ~(|stall);
        ret_ok  = rt.valid & rt.last & ~rt.fault & ~rt.vmexit;
    end

    for (genvar k = 0; k < N_KIND; k++) begin : g_hit
        always_comb begin
            unique case (evt_kind_e'(k))
                EV_CORE:   hits[k] = running;
                EV_REFCYC: hits[k] = running & ref_tick;
                EV_INST:   hits[k] = ret_ok & ~rt.rep_more;
                EV_LREF:   hits[k] = llc_ref;
                EV_LMISS:  hits[k] = llc_miss;
                EV_BRANCH: hits[k] = ret_ok & rt.branch;
                EV_BRMISS: hits[k] = ret_ok & rt.branch & rt.mispred;
                default:   hits[k] = 1'b0;
            endcase
        end
    end

    assign hit = hits[kind];
endmodule

// File: rtl/perf_cnt_accum.sv
module perf_cnt_accum #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         bump,
    input  logic         ovf_clr,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic wrap;
    assign wrap = bump & ~load & (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (load)      count <= load_val;
            else if (bump) count <= count + 1'b1;

            if (wrap)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
    import perf_evt_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             st_lowpwr,
    input  logic             st_halt,
    input  logic             st_stopclk,
    input  logic             st_thermal,
    input  logic             st_fswitch,
    input  logic             ref_tick,
    input  logic             rt_valid,
    input  logic             rt_last,
    input  logic             rt_rep_more,
    input  logic             rt_branch,
    input  logic             rt_mispred,
    input  logic             rt_fault,
    input  logic             rt_vmexit,
    input  logic             llc_ref,
    input  logic             llc_miss,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             unsup_o
);
    cfg_t      cfg_q;
    evt_kind_e evt_kind;
    stall_t    stall;
    retire_t   rt;
    logic      hit;
    logic      bump;
    logic      cnt_load;
    logic      ovf_clr;

    always_ff @(posedge clk) begin
        if (rst)                                  cfg_q <= '0;
        else if (reg_we && reg_addr == ADDR_CFG)  cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
    end

    always_comb begin
        stall    = '{lowpwr: st_lowpwr, halt: st_halt, stopclk: st_stopclk,
                     thermal: st_thermal, fswitch: st_fswitch};
        rt       = '{valid: rt_valid, last: rt_last, rep_more: rt_rep_more,
                     branch: rt_branch, mispred: rt_mispred, fault: rt_fault,
                     vmexit: rt_vmexit};
        cnt_load = reg_we && (reg_addr == ADDR_CNT);
        ovf_clr  = reg_we && (reg_addr == ADDR_STAT) && reg_wdata[0];
        bump     = hit & cfg_q.en;
    end

    perf_evt_decode u_dec (
        .cfg   (cfg_q),
        .kind  (evt_kind),
        .unsup (unsup_o)
    );

    perf_evt_qualify u_qual (
        .kind     (evt_kind),
        .stall    (stall),
        .ref_tick (ref_tick),
        .rt       (rt),
        .llc_ref  (llc_ref),
        .llc_miss (llc_miss),
        .hit      (hit)
    );

    perf_cnt_accum #(.W(CNT_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .bump     (bump),
        .ovf_clr  (ovf_clr),
        .count    (count_o),
        .ovf      (ovf_o)
    );
endmodule

// File: rtl/perf_counter_chk.sv
module perf_counter_chk
    import perf_evt_pkg::*;
#(
    parameter int W = 48
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input cfg_t         cfg,
    input logic         st_halt,
    input logic         bump,
    input logic [W-1:0] count_o,
    input logic         ovf_o,
    input logic         unsup_o
);
    logic cnt_wr;
    assign cnt_wr = reg_we && (reg_addr == ADDR_CNT);

    // R12
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> count_o == $past(reg_wdata));

    // R10
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !cnt_wr) |=> $stable(count_o));

    // R9
    unsup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (unsup_o && !cnt_wr) |=> $stable(count_o));

    // R2
    halt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st_halt && cfg.sel == SEL_CYC && !cnt_wr) |=> $stable(count_o));

    // R11
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bump && !cnt_wr && count_o == {W{1'b1}}) |=> (count_o == '0) && ovf_o);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !(reg_we && reg_addr == ADDR_STAT && reg_wdata[0])) |=> ovf_o);

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (count_o - $past(count_o)) <= W'(1));
endmodule

bind perf_event_counter perf_counter_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg       (cfg_q),
    .st_halt   (st_halt),
    .bump      (bump),
    .count_o   (count_o),
    .ovf_o     (ovf_o),
    .unsup_o   (unsup_o)
);

// File: tb/tb_perf_event_counter.sv
`timescale 1ns/1ps
module tb_perf_event_counter;
    localparam int W = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic st_lowpwr = 0, st_halt = 1, st_stopclk = 0, st_thermal = 0, st_fswitch = 0;
    logic ref_tick = 0;
    logic rt_valid = 0, rt_last = 0, rt_rep_more = 0, rt_branch = 0, rt_mispred = 0;
    logic rt_fault = 0, rt_vmexit = 0, llc_ref = 0, llc_miss = 0;
    logic [W-1:0] count_o;
    logic ovf_o, unsup_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    perf_event_counter dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic idle();
        st_lowpwr = 0; st_halt = 1; st_stopclk = 0; st_thermal = 0; st_fswitch = 0;
        ref_tick = 0; rt_valid = 0; rt_last = 0; rt_rep_more = 0; rt_branch = 0;
        rt_mispred = 0; rt_fault = 0; rt_vmexit = 0; llc_ref = 0; llc_miss = 0;
    endtask

    task automatic sel(input logic [7:0] s, input logic [7:0] q, input logic en);
        wr(2'd0, W'({en, q, s}));
        wr(2'd1, '0);
    endtask

    function automatic bit listed(input logic [7:0] s, input logic [7:0] q);
        return (s == 8'h3C && (q == 8'h00 || q == 8'h01)) ||
               (s == 8'h2E && (q == 8'h4F || q == 8'h41)) ||
               ((s == 8'hC0 || s == 8'hC4 || s == 8'hC5) && q == 8'h00);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] quals [5] = '{8'h00, 8'h01, 8'h41, 8'h4F, 8'hFF};
        idle();
        step(); step();
        rst = 0;
        step();
        // reset state
        check("reset count", count_o, '0);
        check("reset ovf", W'(ovf_o), '0);
        check("R9 reset unsup", W'(unsup_o), W'(1));

        // R9 R7 R8 sweep: all strobes one cycle
        for (int s = 0; s < 256; s++) begin
            for (int qi = 0; qi < 5; qi++) begin
                sel(8'(s), quals[qi], 1'b1);
                st_halt = 0; ref_tick = 1; rt_valid = 1; rt_last = 1;
                rt_branch = 1; rt_mispred = 1; llc_ref = 1; llc_miss = 1;
                step();
                idle();
                check("R9 sweep count", count_o, W'(listed(8'(s), quals[qi])));
                check("R9 sweep unsup", W'(unsup_o), W'(!listed(8'(s), quals[qi])));
            end
        end

        // R1 free-running core cycles
        sel(8'h3C, 8'h00, 1); st_halt = 0;
        repeat (4) step();
        idle();
        check("R1 core cycles", count_o, W'(4));

        // R2 each stop cause alone, both cycle events
        for (int q = 0; q < 2; q++) begin
            for (int c = 0; c < 5; c++) begin
                sel(8'h3C, 8'(q), 1);
                st_halt = (c == 1); st_lowpwr = (c == 0); st_stopclk = (c == 2);
                st_thermal = (c == 3); st_fswitch = (c == 4); ref_tick = 1;
                repeat (3) step();
                idle();
                check("R2 stop cause", count_o, '0);
            end
        end

        // R3 reference ticks on alternate cycles
        sel(8'h3C, 8'h01, 1); st_halt = 0;
        for (int i = 0; i < 6; i++) begin ref_tick = (i % 2 == 0); step(); end
        idle();
        check("R3 ref ticks", count_o, W'(3));

        // R4 three micro-ops, last one final
        sel(8'hC0, 8'h00, 1); rt_valid = 1;
        step(); step(); rt_last = 1; step();
        idle();
        check("R4 last uop only", count_o, W'(1));

        // R5 repeated instruction, four iterations
        sel(8'hC0, 8'h00, 1); rt_valid = 1; rt_last = 1; rt_rep_more = 1;
        repeat (3) step();
        rt_rep_more = 0; step();
        idle();
        check("R5 rep once", count_o, W'(1));

        // R6 fault and vm exit suppress retirement events
        for (int e = 0; e < 3; e++) begin
            sel(e == 0 ? 8'hC0 : (e == 1 ? 8'hC4 : 8'hC5), 8'h00, 1);
            rt_valid = 1; rt_last = 1; rt_branch = 1; rt_mispred = 1; rt_fault = 1;
            step();
            rt_fault = 0; rt_vmexit = 1; step();
            rt_vmexit = 0; step();
            idle();
            check("R6 fault/vmexit", count_o, W'(1));
        end

        // R7 miss and reference independent
        sel(8'h2E, 8'h41, 1); llc_ref = 1; step(); llc_miss = 1; step(); step();
        idle();
        check("R7 llc miss", count_o, W'(2));
        sel(8'h2E, 8'h4F, 1); llc_ref = 1; step(); step(); llc_ref = 0; llc_miss = 1; step();
        idle();
        check("R7 llc ref", count_o, W'(2));

        // R8 mispredict needs a branch
        sel(8'hC5, 8'h00, 1); rt_valid = 1; rt_last = 1; rt_mispred = 1; step();
        rt_branch = 1; step(); rt_mispred = 0; step();
        idle();
        check("R8 mispredict", count_o, W'(1));
        sel(8'hC4, 8'h00, 1); rt_valid = 1; rt_last = 1; rt_branch = 1; step(); step();
        rt_last = 0; step();
        idle();
        check("R8 branch", count_o, W'(2));

        // R10 disabled
        sel(8'h3C, 8'h00, 0); st_halt = 0;
        repeat (5) step();
        idle();
        check("R10 disabled", count_o, '0);

        // R11 wrap and sticky flag
        sel(8'h3C, 8'h00, 1);
        wr(2'd1, {W{1'b1}} - W'(1));
        st_halt = 0; step(); step(); step();
        idle();
        check("R11 wrap count", count_o, W'(1));
        check("R11 ovf set", W'(ovf_o), W'(1));
        wr(2'd2, W'(0));
        check("R11 ovf kept", W'(ovf_o), W'(1));
        wr(2'd2, W'(1));
        check("R11 ovf cleared", W'(ovf_o), '0);

        // R12 write beats increment
        sel(8'h3C, 8'h00, 1); st_halt = 0;
        step();
        wr(2'd1, W'(5));
        check("R12 write wins", count_o, W'(5));
        step();
        idle();
        check("R12 counts on", count_o, W'(6));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule